// File: doc/BRIEF.md
# I2C Master Command and Receive Queue

This block sits between a 32-bit register bus and the bit-level engine of an I2C master. Software queues bus work through one data/command register. A write with bit 8 clear queues the byte in bits 7:0 for transmission. A write with bit 8 set queues a read command. A read of the same register pops the oldest byte the engine has received. The engine takes queued commands over a valid/ready handshake and returns received bytes with a one-cycle valid strobe.

Both queue fill levels can be read back. Two programmable thresholds drive level flags: one asks software for more commands, the other says received data is waiting. An enable register gates the handshake toward the engine. An abort from the engine empties both queues. Queuing a command while the controller is disabled is also treated as an abort: the command is refused, both queues are emptied and a cause pulse is raised. The depth of each queue is a parameter, 8 by default.

Register map (byte offsets on `reg_addr`): 0x10 data/command, 0x38 receive threshold, 0x3C transmit threshold, 0x6C enable (bit 0), 0x70 status (bit 0 = engine busy), 0x74 transmit level, 0x78 receive level. A read returns its value on `reg_rdata` from the clock edge that samples `reg_rd`. Every pulse output is registered and is high for the one cycle after the edge that caused it.

Top module: `i2c_cmdq_frontend`

## Requirements
- R1: A write to 0x10 while enabled queues {bit 8, bits 7:0} as one command. Commands appear on `cmd_is_read`/`cmd_byte` in the order they were written, with `cmd_is_read` equal to bit 8. A command leaves the queue on each cycle where `cmd_valid` and `cmd_ready` are both high.
- R2: A read of 0x10 with received data present returns the oldest byte in bits 7:0, with zeros above, and removes it. Bytes come out in the order of `rsp_valid`. Offsets 0x74 and 0x78 return the transmit and receive fill levels.
- R3: `tx_empty` is high exactly while the transmit level is less than or equal to the threshold written at 0x3C. The threshold resets to 0.
- R4: `rx_full` is high exactly while the receive level is greater than the threshold written at 0x38. The threshold resets to 0.
- R5: A data write while the transmit queue holds DEPTH commands is dropped, the level stays the same, and `tx_over` pulses.
- R6: A read of 0x10 while the receive queue is empty returns 0 and pulses `rx_under`.
- R7: An `rsp_valid` byte that arrives while the receive queue is full is dropped and `rx_over` pulses.
- R8: `abort_in` empties both queues at the next edge, and any push in that same cycle is discarded.
- R9: The enable register (0x6C, bit 0) resets to 0 and drives `ctrl_enable`. `cmd_valid` is high only while the controller is enabled and a command is queued.
- R10: A data write while disabled is not queued. It pulses `abort_disabled` and empties both queues.
- R11: Bit 0 of the status register at 0x70 reads the `eng_busy` input. The other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| cmd_valid | output | 1 | A command is offered to the engine |
| cmd_ready | input | 1 | The engine accepts the command |
| cmd_is_read | output | 1 | Offered command is a read |
| cmd_byte | output | 8 | Offered write byte |
| rsp_valid | input | 1 | Received byte strobe |
| rsp_byte | input | 8 | Received byte |
| eng_busy | input | 1 | Engine is active on the bus |
| abort_in | input | 1 | Transfer abort from the engine |
| ctrl_enable | output | 1 | Enable register bit |
| tx_empty | output | 1 | Transmit level at or below its threshold |
| rx_full | output | 1 | Receive level above its threshold |
| tx_over | output | 1 | Pulse: data write dropped on a full queue |
| rx_under | output | 1 | Pulse: data read on an empty queue |
| rx_over | output | 1 | Pulse: received byte dropped on a full queue |
| abort_disabled | output | 1 | Pulse: command queued while disabled |

## Verification
The hardest cases to reach are the ones that need a queue held exactly at DEPTH while another event lands on it: a ninth command write, a ninth received byte, or an abort in the same cycle as a push. To get there, the bench holds `cmd_ready` low so commands pile up, fills each queue through the normal ports, and checks the level through the register bus before and after the extra event. A scoreboard queue records every accepted command. A monitor then drains the queue with `cmd_ready` high and compares the commands in order, so a dropped, duplicated or reordered entry shows up as a mismatch.

// File: rtl/i2c_cmdq_pkg.sv
package i2c_cmdq_pkg;
   localparam int REG_AW = 8;
   localparam int REG_DW = 32;
   localparam int BYTE_W = 8;
   localparam int CMD_W  = BYTE_W + 1;

   localparam logic [REG_AW-1:0] OFS_DATA   = 8'h10;
   localparam logic [REG_AW-1:0] OFS_RX_THR = 8'h38;
   localparam logic [REG_AW-1:0] OFS_TX_THR = 8'h3C;
   localparam logic [REG_AW-1:0] OFS_ENABLE = 8'h6C;
   localparam logic [REG_AW-1:0] OFS_STATUS = 8'h70;
   localparam logic [REG_AW-1:0] OFS_TX_LVL = 8'h74;
   localparam logic [REG_AW-1:0] OFS_RX_LVL = 8'h78;

   localparam int RD_FLAG_BIT = 8;

   typedef struct packed {
      logic              is_read;
      logic [BYTE_W-1:0] data;
   } cmd_t;
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             full,
   output logic             empty,
   output logic [CNT_W-1:0] level
);
   generate
      if (DEPTH < 2) begin : g_depth_bad
         $error("cmdq_fifo: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_width_bad
         $error("cmdq_fifo: WIDTH must be positive");
      end
   endgenerate

   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] cnt;
   logic             do_push, do_pop;

   assign full    = (cnt == FULL_CNT);
   assign empty   = (cnt == '0);
   assign level   = cnt;
   assign head    = mem[rd_ptr];
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wr_ptr] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) begin
            wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         end
         if (do_pop) begin
            rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         end
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R1
   push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !pop && !flush) |=> (level == $past(level) + 1'b1));

   // R5
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (level == $past(level)));
endmodule

// File: rtl/cmdq_level_flag.sv
module cmdq_level_flag #(
   parameter int  CNT_W = 4,
   parameter bit  ABOVE = 1'b0
) (
   input  logic [CNT_W-1:0] level,
   input  logic [CNT_W-1:0] thresh,
   output logic             flag
);
   generate
      if (CNT_W < 1) begin : g_cw_bad
         $error("cmdq_level_flag: CNT_W must be positive");
      end
      if (ABOVE) begin : g_above
         assign flag = (level > thresh);
      end else begin : g_at_or_below
         assign flag = (level <= thresh);
      end
   endgenerate
endmodule

// File: rtl/i2c_cmdq_frontend.sv
module i2c_cmdq_frontend
   import i2c_cmdq_pkg::*;
#(
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  reg_addr,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        cmd_valid,
   input  logic        cmd_ready,
   output logic        cmd_is_read,
   output logic [7:0]  cmd_byte,
   input  logic        rsp_valid,
   input  logic [7:0]  rsp_byte,
   input  logic        eng_busy,
   input  logic        abort_in,
   output logic        ctrl_enable,
   output logic        tx_empty,
   output logic        rx_full,
   output logic        tx_over,
   output logic        rx_under,
   output logic        rx_over,
   output logic        abort_disabled
);
   localparam int TX_CW = $clog2(TX_DEPTH + 1);
   localparam int RX_CW = $clog2(RX_DEPTH + 1);

   generate
      if (TX_CW > REG_DW || RX_CW > REG_DW) begin : g_cw_bad
         $error("i2c_cmdq_frontend: depth too large for register width");
      end
   endgenerate

   logic             en_q;
   logic [TX_CW-1:0] tx_thr_q, tx_lvl;
   logic [RX_CW-1:0] rx_thr_q, rx_lvl;
   logic             tx_full_f, tx_empty_f, rx_full_f, rx_empty_f;
   cmd_t             tx_head, tx_in;
   logic [BYTE_W-1:0] rx_head;

   logic wr_data_hit, rd_data_hit, flush_all, abort_dis_now;
   logic tx_push, tx_pop, rx_pop;
   logic unused_wdata;

   assign unused_wdata  = ^reg_wdata[REG_DW-1:CMD_W];
   assign wr_data_hit   = reg_wr && (reg_addr == OFS_DATA);
   assign rd_data_hit   = reg_rd && (reg_addr == OFS_DATA);
   assign abort_dis_now = wr_data_hit && !en_q;
   assign flush_all     = abort_in || abort_dis_now;
   assign tx_push       = wr_data_hit && en_q;
   assign tx_pop        = cmd_valid && cmd_ready;
   assign rx_pop        = rd_data_hit && !rx_empty_f;

   assign tx_in.is_read = reg_wdata[RD_FLAG_BIT];
   assign tx_in.data    = reg_wdata[BYTE_W-1:0];

   cmdq_fifo #(.WIDTH(CMD_W), .DEPTH(TX_DEPTH)) u_tx_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_all),
      .push      (tx_push),
      .push_data (tx_in),
      .pop       (tx_pop),
      .head      (tx_head),
      .full      (tx_full_f),
      .empty     (tx_empty_f),
      .level     (tx_lvl)
   );

   cmdq_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rx_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_all),
      .push      (rsp_valid),
      .push_data (rsp_byte),
      .pop       (rx_pop),
      .head      (rx_head),
      .full      (rx_full_f),
      .empty     (rx_empty_f),
      .level     (rx_lvl)
   );

   cmdq_level_flag #(.CNT_W(TX_CW), .ABOVE(1'b0)) u_tx_flag (
      .level  (tx_lvl),
      .thresh (tx_thr_q),
      .flag   (tx_empty)
   );

   cmdq_level_flag #(.CNT_W(RX_CW), .ABOVE(1'b1)) u_rx_flag (
      .level  (rx_lvl),
      .thresh (rx_thr_q),
      .flag   (rx_full)
   );

   assign cmd_valid   = en_q && !tx_empty_f;
   assign cmd_is_read = tx_head.is_read;
   assign cmd_byte    = tx_head.data;
   assign ctrl_enable = en_q;

   // configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         tx_thr_q <= '0;
         rx_thr_q <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            OFS_ENABLE: en_q     <= reg_wdata[0];
            OFS_TX_THR: tx_thr_q <= reg_wdata[TX_CW-1:0];
            OFS_RX_THR: rx_thr_q <= reg_wdata[RX_CW-1:0];
            default:    ;
         endcase
      end
   end

   // read port and event pulses
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata      <= '0;
         tx_over        <= 1'b0;
         rx_under       <= 1'b0;
         rx_over        <= 1'b0;
         abort_disabled <= 1'b0;
      end else begin
         tx_over        <= tx_push && tx_full_f;
         rx_under       <= rd_data_hit && rx_empty_f;
         rx_over        <= rsp_valid && rx_full_f;
         abort_disabled <= abort_dis_now;
         if (reg_rd) begin
            case (reg_addr)
               OFS_DATA:   reg_rdata <= rx_empty_f ? '0 : REG_DW'(rx_head);
               OFS_RX_THR: reg_rdata <= REG_DW'(rx_thr_q);
               OFS_TX_THR: reg_rdata <= REG_DW'(tx_thr_q);
               OFS_ENABLE: reg_rdata <= REG_DW'(en_q);
               OFS_STATUS: reg_rdata <= REG_DW'(eng_busy);
               OFS_TX_LVL: reg_rdata <= REG_DW'(tx_lvl);
               OFS_RX_LVL: reg_rdata <= REG_DW'(rx_lvl);
               default:    reg_rdata <= '0;
            endcase
         end
      end
   end

   // R8
   abort_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_in |=> (tx_lvl == '0 && rx_lvl == '0));

   // R10
   dis_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_disabled |-> (tx_lvl == '0 && rx_lvl == '0));

   // R5
   tx_over_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_over |-> $past(wr_data_hit && tx_full_f));

   // R6
   rx_under_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_under |-> (reg_rdata == '0));

   // R7
   rx_over_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_over |-> $past(rsp_valid && rx_full_f));

   // R9
   valid_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_enable && !tx_push) |=> (tx_lvl <= $past(tx_lvl)));
endmodule

// File: tb/i2c_cmdq_frontend_tb.sv
`timescale 1ns/1ps
module i2c_cmdq_frontend_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cmd_valid, cmd_ready = 1'b0, cmd_is_read;
   logic [7:0]  cmd_byte;
   logic        rsp_valid = 1'b0;
   logic [7:0]  rsp_byte = '0;
   logic        eng_busy = 1'b0, abort_in = 1'b0;
   logic        ctrl_enable, tx_empty, rx_full, tx_over, rx_under, rx_over, abort_disabled;

   int checks = 0, fails = 0, popped = 0;
   bit done = 1'b0;
   logic [8:0] sb_q[$];

   always #2 clk = ~clk;

   i2c_cmdq_frontend dut_i (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a; reg_rd = 1'b1;
      step();
      d = reg_rdata;
      reg_rd = 1'b0;
   endtask

   // driver: queues a command and records what should come out
   task automatic send_cmd(input logic is_rd, input logic [7:0] b);
      wr(8'h10, {23'b0, is_rd, b});
      sb_q.push_back({is_rd, b});
   endtask

   task automatic give_rx(input logic [7:0] b);
      rsp_valid = 1'b1; rsp_byte = b;
      step();
      rsp_valid = 1'b0;
   endtask

   // monitor: compares each accepted command against the scoreboard (R1)
   always begin
      @(negedge clk);
      #1;
      if (rst_n && cmd_valid && cmd_ready) begin
         if (sb_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R1: actual 0x%0h expected none", {cmd_is_read, cmd_byte});
         end else begin
            check("R1", {23'b0, cmd_is_read, cmd_byte}, {23'b0, sb_q.pop_front()});
            popped++;
         end
      end
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      step(); step();
      rst_n = 1'b1;
      step();

      // reset state
      check("R9 reset enable", {31'b0, ctrl_enable}, 0);
      check("R3 reset tx_empty", {31'b0, tx_empty}, 1);
      check("R4 reset rx_full", {31'b0, rx_full}, 0);
      check("R9 reset cmd_valid", {31'b0, cmd_valid}, 0);
      rd(8'h6C, v); check("R9 enable reg", v, 0);

      // R10: queue while disabled flushes
      give_rx(8'h11); give_rx(8'h22);
      rd(8'h78, v); check("R2 rx level", v, 2);
      wr(8'h10, 32'h0AB);
      check("R10 abort pulse", {31'b0, abort_disabled}, 1);
      rd(8'h78, v); check("R10 rx flushed", v, 0);
      rd(8'h74, v); check("R10 tx not queued", v, 0);
      check("R10 pulse one cycle", {31'b0, abort_disabled}, 0);

      // enable and queue commands with the engine stalled
      wr(8'h6C, 1);
      check("R9 ctrl_enable", {31'b0, ctrl_enable}, 1);
      send_cmd(1'b0, 8'h55); send_cmd(1'b1, 8'h00); send_cmd(1'b0, 8'hA3);
      check("R9 cmd_valid", {31'b0, cmd_valid}, 1);
      rd(8'h74, v); check("R2 tx level", v, 3);
      check("R3 above thr", {31'b0, tx_empty}, 0);
      wr(8'h3C, 3); check("R3 equal thr", {31'b0, tx_empty}, 1);
      wr(8'h3C, 2); check("R3 one below", {31'b0, tx_empty}, 0);
      for (int i = 0; i < 5; i++) send_cmd(i[0], 8'hC0 + 8'(i));
      rd(8'h74, v); check("R5 tx full level", v, 8);
      wr(8'h10, 32'h077);
      check("R5 tx_over", {31'b0, tx_over}, 1);
      rd(8'h74, v); check("R5 level kept", v, 8);

      // R9: disabling holds commands back
      wr(8'h6C, 0);
      cmd_ready = 1'b1;
      step();
      check("R9 no valid when disabled", {31'b0, cmd_valid}, 0);
      rd(8'h74, v); check("R9 nothing taken", v, 8);
      cmd_ready = 1'b0;
      wr(8'h6C, 1);

      // drain through the monitor
      cmd_ready = 1'b1;
      for (int i = 0; i < 40 && cmd_valid; i++) step();
      cmd_ready = 1'b0;
      check("R1 all drained", popped, 8);
      check("R1 scoreboard empty", sb_q.size(), 0);

      // receive path
      for (int i = 0; i < 8; i++) give_rx(8'h30 + 8'(i));
      check("R4 above thr0", {31'b0, rx_full}, 1);
      wr(8'h38, 8); check("R4 equal thr", {31'b0, rx_full}, 0);
      wr(8'h38, 7); check("R4 one below", {31'b0, rx_full}, 1);
      give_rx(8'hEE);
      check("R7 rx_over", {31'b0, rx_over}, 1);
      rd(8'h78, v); check("R7 level kept", v, 8);
      for (int i = 0; i < 8; i++) begin
         rd(8'h10, v); check("R2 rx order", v, 32'h30 + i);
      end
      rd(8'h10, v);
      check("R6 zero data", v, 0);
      check("R6 rx_under", {31'b0, rx_under}, 1);

      // R8: abort with a push in the same cycle
      send_cmd(1'b0, 8'h01); send_cmd(1'b0, 8'h02);
      give_rx(8'h44);
      abort_in = 1'b1; rsp_valid = 1'b1; rsp_byte = 8'h45;
      step();
      abort_in = 1'b0; rsp_valid = 1'b0;
      sb_q.delete();
      rd(8'h74, v); check("R8 tx flushed", v, 0);
      rd(8'h78, v); check("R8 rx flushed", v, 0);
      check("R8 no valid", {31'b0, cmd_valid}, 0);

      // R11: status
      eng_busy = 1'b1; rd(8'h70, v); check("R11 busy", v, 1);
      eng_busy = 1'b0; rd(8'h70, v); check("R11 idle", v, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule